// File: doc/BRIEF.md
# Dual-Channel Regulator Start-up and Fault Supervisor

This block is the digital sequencer that sits beside the analog front end of a two-channel buck regulator. The comparators and the soft-start capacitor stay analog; the block sees their results as logic flags. From those flags it decides when each channel may switch, when a channel must pull its output down through the low-side switch, when a channel reports power-good, and when the whole chip is held off after a fault.

Start-up passes through four states: off, soft-start, armed run and latched off. Power-good, overvoltage pull-down and the latching checks work only in the armed run state. That state is entered once the soft-start level reaches its completion threshold. Every analog comparator flag goes through a deglitch filter of `FILT_LEN` clocks first. The overcurrent request is already a digital decision and acts on the next edge.

A memory-rail strap makes channel 1 a tracking rail. Its power-good pin then carries a buffered reference, and its overcurrent and overvoltage responses are masked. All pins are plain control and status levels, with no data stream and no handshake.

Top module: `pwrsup_top`

## Requirements
- R1: A rising-supply flag (`vcc_hi_i`) sets an internal supply-good latch, and a falling-supply flag (`vcc_lo_i`) clears it. With the latch clear, the block leaves any state for off on the next clock. It leaves off only with the latch set and at least one enable high. `run_o[i]` is high in soft-start and armed run while `en_i[i]` is high.
- R2: From off, the block always spends at least one clock in soft-start, with `ss_chg_o` high and `armed_o` low. It moves to armed run (`armed_o`=1) on the clock after `ss_done_i` is seen high.
- R3: `pgood_o[i]` is high exactly when the block is armed, `en_i[i]` is high and the filtered window flag of channel i is high.
- R4: While armed and enabled, a filtered overvoltage flag drives `force_lo_o[i]` high. Here 1 means low side on and high side off, and this overrides `run_o`. It returns low as soon as the filtered flag drops, with no latch.
- R5: While armed, a filtered undervoltage flag on any enabled channel moves the block to latched off on the next clock. There `latched_o`=1 and all `run_o`, `pgood_o` and `ss_chg_o` are 0.
- R6: While armed, `oc_req_i[i]` high on an enabled, unmasked channel latches the chip off on the next clock.
- R7: Latched off persists until the supply-good latch clears or both enables are low. Either event moves the block to off on the next clock.
- R8: With `mem_mode_i`=1, `pgood_o[1]` and `force_lo_o[1]` stay 0 and `oc_req_i[1]` is ignored. `ref_out_o` is high whenever the block is in soft-start or armed run.
- R9: A filtered over-temperature flag moves the block from soft-start or armed run to off. The block restarts through soft-start only after the filtered flag clears.
- R10: A comparator flag (window, overvoltage, undervoltage, over-temperature) takes effect only after holding a new level for `FILT_LEN` consecutive clocks. A shorter pulse has no effect.
- R11: With both enables low, the block is in off from the next clock. `run_o`, `pgood_o` and `latched_o` are then all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| vcc_hi_i | input | 1 | supply above rising threshold |
| vcc_lo_i | input | 1 | supply below falling threshold |
| en_i | input | NCH | per-channel enable |
| mem_mode_i | input | 1 | memory-rail strap |
| ss_done_i | input | 1 | soft-start level at completion threshold |
| win_ok_i | input | NCH | output inside ±10% window |
| ov_i | input | NCH | output above 115% |
| uv_i | input | NCH | output below 75% |
| ot_i | input | 1 | over-temperature |
| oc_req_i | input | NCH | overcurrent latch request |
| run_o | output | NCH | channel switching enable |
| force_lo_o | output | NCH | low side on, high side off |
| pgood_o | output | NCH | power-good |
| ref_out_o | output | 1 | channel-1 pin acts as reference buffer |
| ss_chg_o | output | 1 | soft-start capacitor charging |
| armed_o | output | 1 | soft-start complete, checks armed |
| latched_o | output | 1 | chip latched off |

## Verification
The bench runs a full start-up, with soft-start held incomplete for several cycles, and then applies each fault flag separately. Overvoltage pulses one cycle shorter than the filter length are set against pulses of full length. This separates the deglitch filter from the direct response. The two latching faults are each cleared once by dropping the enables and once by a supply dip, which shows that both exits work. Memory mode repeats the channel-1 overcurrent and overvoltage stimulus to show the masking, and over-temperature checks that the restart passes through soft-start.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_SOFT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_LATCH = 2'd3
  } sup_state_t;
endpackage

// File: rtl/pwrsup_deglitch.sv
module pwrsup_deglitch #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN);
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      clean_o <= 1'b0;
    end else if (raw_i == clean_o) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      clean_o <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwrsup_seq.sv
module pwrsup_seq
  import pwrsup_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vcc_hi_i,
  input  logic           vcc_lo_i,
  input  logic [NCH-1:0] en_i,
  input  logic           mem_mode_i,
  input  logic           ss_done_i,
  input  logic           ot_f,
  input  logic [NCH-1:0] uv_f,
  input  logic [NCH-1:0] oc_req_i,
  output sup_state_t     state_o
);
  logic           por_q;
  logic           por_now;
  logic [NCH-1:0] oc_mask;
  logic           trip;
  sup_state_t     nxt;

  // the last channel becomes the tracking rail in memory mode
  for (genvar i = 0; i < NCH; i++) begin : g_mask
    if (i == NCH - 1) begin : g_trk
      assign oc_mask[i] = en_i[i] & ~mem_mode_i;
    end else begin : g_std
      assign oc_mask[i] = en_i[i];
    end
  end

  assign por_now = vcc_hi_i | (por_q & ~vcc_lo_i);
  assign trip    = |(uv_f & en_i) | |(oc_req_i & oc_mask);

  always_comb begin
    nxt = state_o;
    if (!por_now || !(|en_i)) begin
      nxt = ST_OFF;
    end else if (state_o != ST_LATCH) begin
      if (ot_f) begin
        nxt = ST_OFF;
      end else begin
        unique case (state_o)
          ST_OFF:  nxt = ST_SOFT;
          ST_SOFT: nxt = ss_done_i ? ST_RUN : ST_SOFT;
          ST_RUN:  nxt = trip ? ST_LATCH : ST_RUN;
          default: nxt = ST_OFF;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q   <= 1'b0;
      state_o <= ST_OFF;
    end else begin
      por_q   <= por_now;
      state_o <= nxt;
    end
  end
endmodule

// File: rtl/pwrsup_outmap.sv
module pwrsup_outmap
  import pwrsup_pkg::*;
#(
  parameter int NCH = 2
) (
  input  sup_state_t     state_i,
  input  logic [NCH-1:0] en_i,
  input  logic           mem_mode_i,
  input  logic [NCH-1:0] win_f,
  input  logic [NCH-1:0] ov_f,
  output logic [NCH-1:0] run_o,
  output logic [NCH-1:0] force_lo_o,
  output logic [NCH-1:0] pgood_o,
  output logic           ref_out_o,
  output logic           ss_chg_o,
  output logic           armed_o,
  output logic           latched_o
);
  logic active;

  assign active    = (state_i == ST_SOFT) || (state_i == ST_RUN);
  assign armed_o   = (state_i == ST_RUN);
  assign latched_o = (state_i == ST_LATCH);
  assign ss_chg_o  = active;
  assign ref_out_o = active & mem_mode_i;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic own;
    if (i == NCH - 1) begin : g_trk
      assign own = ~mem_mode_i;
    end else begin : g_std
      assign own = 1'b1;
    end
    assign run_o[i]      = active & en_i[i];
    assign pgood_o[i]    = armed_o & en_i[i] & win_f[i] & own;
    assign force_lo_o[i] = armed_o & en_i[i] & ov_f[i] & own;
  end
endmodule

// File: rtl/pwrsup_top.sv
module pwrsup_top
  import pwrsup_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int FILT_LEN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vcc_hi_i,
  input  logic           vcc_lo_i,
  input  logic [NCH-1:0] en_i,
  input  logic           mem_mode_i,
  input  logic           ss_done_i,
  input  logic [NCH-1:0] win_ok_i,
  input  logic [NCH-1:0] ov_i,
  input  logic [NCH-1:0] uv_i,
  input  logic           ot_i,
  input  logic [NCH-1:0] oc_req_i,
  output logic [NCH-1:0] run_o,
  output logic [NCH-1:0] force_lo_o,
  output logic [NCH-1:0] pgood_o,
  output logic           ref_out_o,
  output logic           ss_chg_o,
  output logic           armed_o,
  output logic           latched_o
);
  localparam int FW = 3 * NCH + 1;

  logic [FW-1:0] raw_flags;
  logic [FW-1:0] flt_flags;
  logic [NCH-1:0] win_f, ov_f, uv_f;
  logic ot_f;
  sup_state_t state;

  assign raw_flags = {ot_i, uv_i, ov_i, win_ok_i};

  for (genvar k = 0; k < FW; k++) begin : g_flt
    pwrsup_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_flags[k]), .clean_o(flt_flags[k])
    );
  end

  assign win_f = flt_flags[NCH-1:0];
  assign ov_f  = flt_flags[2*NCH-1:NCH];
  assign uv_f  = flt_flags[3*NCH-1:2*NCH];
  assign ot_f  = flt_flags[FW-1];

  pwrsup_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .vcc_hi_i(vcc_hi_i), .vcc_lo_i(vcc_lo_i),
    .en_i(en_i), .mem_mode_i(mem_mode_i), .ss_done_i(ss_done_i),
    .ot_f(ot_f), .uv_f(uv_f), .oc_req_i(oc_req_i), .state_o(state)
  );

  pwrsup_outmap #(.NCH(NCH)) u_map (
    .state_i(state), .en_i(en_i), .mem_mode_i(mem_mode_i),
    .win_f(win_f), .ov_f(ov_f), .run_o(run_o), .force_lo_o(force_lo_o),
    .pgood_o(pgood_o), .ref_out_o(ref_out_o), .ss_chg_o(ss_chg_o),
    .armed_o(armed_o), .latched_o(latched_o)
  );
endmodule

// File: rtl/pwrsup_chk.sv
module pwrsup_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           vcc_hi_i,
  input logic           vcc_lo_i,
  input logic [NCH-1:0] en_i,
  input logic           mem_mode_i,
  input logic [NCH-1:0] run_o,
  input logic [NCH-1:0] force_lo_o,
  input logic [NCH-1:0] pgood_o,
  input logic           ss_chg_o,
  input logic           armed_o,
  input logic           latched_o
);
  // R11
  both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|en_i) |=> (run_o == '0 && pgood_o == '0 && !latched_o));

  // R1
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_lo_i && !vcc_hi_i) |=> (run_o == '0 && !ss_chg_o && !latched_o));

  // R3
  pg_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pgood_o) |-> armed_o);

  // R5
  latch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched_o) |-> $past(armed_o));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_o && !vcc_lo_i && (|en_i)) |=> latched_o);

  // R8
  mem_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_mode_i |-> (!pgood_o[NCH-1] && !force_lo_o[NCH-1]));

  // R2
  soft_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_chg_o) |-> !armed_o);
endmodule

bind pwrsup_top pwrsup_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/pwrsup_top_test.sv
module pwrsup_top_test;
  localparam int NCH  = 2;
  localparam int FILT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_hi = 1'b0, vcc_lo = 1'b0, mem = 1'b0, ssd = 1'b0, ot = 1'b0;
  logic [NCH-1:0] en = '0, win = '0, ov = '0, uv = '0, ocr = '0;
  logic [NCH-1:0] run, flo, pg;
  logic ref_o, ssc, armed, latched;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pwrsup_top #(.NCH(NCH), .FILT_LEN(FILT)) uut (
    .clk(clk), .rst_n(rst_n), .vcc_hi_i(vcc_hi), .vcc_lo_i(vcc_lo), .en_i(en),
    .mem_mode_i(mem), .ss_done_i(ssd), .win_ok_i(win), .ov_i(ov), .uv_i(uv),
    .ot_i(ot), .oc_req_i(ocr), .run_o(run), .force_lo_o(flo), .pgood_o(pg),
    .ref_out_o(ref_o), .ss_chg_o(ssc), .armed_o(armed), .latched_o(latched)
  );

  // reference model: m_st 0 off, 1 soft, 2 run, 3 latched
  int m_st;
  bit m_por;
  bit m_fo[7];
  int m_cnt[7];

  function automatic bit raw_bit(int k);
    case (k)
      0: return win[0];
      1: return win[1];
      2: return ov[0];
      3: return ov[1];
      4: return uv[0];
      5: return uv[1];
      default: return ot;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_por = 0;
      for (int k = 0; k < 7; k++) begin m_fo[k] = 0; m_cnt[k] = 0; end
    end else begin
      bit pnow, trip;
      int nx;
      pnow = vcc_hi || (m_por && !vcc_lo);
      trip = (en[0] && m_fo[4]) || (en[1] && m_fo[5]) ||
             (en[0] && ocr[0]) || (en[1] && ocr[1] && !mem);
      nx = m_st;
      if (!pnow || en == 0) nx = 0;
      else if (m_st != 3) begin
        if (m_fo[6]) nx = 0;
        else if (m_st == 0) nx = 1;
        else if (m_st == 1) nx = ssd ? 2 : 1;
        else if (m_st == 2) nx = trip ? 3 : 2;
      end
      m_por = pnow;
      m_st = nx;
      for (int k = 0; k < 7; k++) begin
        bit r;
        r = raw_bit(k);
        if (r == m_fo[k]) m_cnt[k] = 0;
        else if (m_cnt[k] == FILT - 1) begin m_fo[k] = r; m_cnt[k] = 0; end
        else m_cnt[k]++;
      end
    end
  end

  task automatic ck(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit act;
      logic [1:0] e_run, e_pg, e_flo;
      act = (m_st == 1 || m_st == 2);
      for (int i = 0; i < 2; i++) begin
        bit own;
        own = !(i == 1 && mem);
        e_run[i] = act && en[i];
        e_pg[i]  = (m_st == 2) && en[i] && m_fo[i] && own;
        e_flo[i] = (m_st == 2) && en[i] && m_fo[2+i] && own;
      end
      ck(run == e_run, "R1 run", run, e_run);
      ck(armed == (m_st == 2), "R2 armed", armed, m_st == 2);
      ck(pg == e_pg, "R3 pgood", pg, e_pg);
      ck(flo == e_flo, "R4 force_lo", flo, e_flo);
      ck(latched == (m_st == 3), "R5 latched", latched, m_st == 3);
      ck(ref_o == (act && mem), "R8 ref_out", ref_o, act && mem);
      ck(ssc == act, "R2 ss_chg", ssc, act);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    ck(run == 0 && pg == 0 && !latched, "R11 reset state", {run, pg}, 0);
    en = 2'b11; step(3);
    ck(run == 0, "R1 no start without supply", run, 0);
    vcc_hi = 1; step(1); vcc_hi = 0;
    ck(run == 2'b11 && ssc, "R1 start after rising supply", run, 3);
    ck(!armed, "R2 soft-start before arming", armed, 0);
    step(3);
    ck(!armed, "R2 held in soft-start", armed, 0);
    ssd = 1; step(1);
    ck(armed, "R2 armed at completion", armed, 1);
    win = 2'b11; step(FILT - 1);
    ck(pg == 0, "R10 window filter still counting", pg, 0);
    step(1);
    ck(pg == 2'b11, "R3 pgood after window", pg, 3);
    ov[0] = 1; step(FILT - 1); ov = 0; step(FILT);
    ck(flo == 0, "R10 short overvoltage pulse ignored", flo, 0);
    ov[0] = 1; step(FILT);
    ck(flo == 2'b01 && !latched, "R4 overvoltage forces low side", flo, 1);
    ov = 0; step(FILT);
    ck(flo == 0 && !latched, "R4 overvoltage self-clears", flo, 0);
    win[1] = 0; step(FILT);
    ck(pg == 2'b01, "R3 pgood drops out of window", pg, 1);
    uv[1] = 1; step(FILT + 1);
    ck(latched && run == 0, "R5 undervoltage latches", latched, 1);
    uv = 0; win = 0; step(3);
    ck(latched, "R7 latch persists", latched, 1);
    en = 0; step(1);
    ck(!latched && pg == 0 && run == 0, "R11 enables low clear", latched, 0);
    en = 2'b11; step(1);
    ck(ssc && !armed, "R7 restart through soft-start", ssc, 1);
    step(FILT + 1);
    ocr = 2'b01; step(1); ocr = 0;
    ck(latched, "R6 overcurrent request latches", latched, 1);
    vcc_lo = 1; step(1);
    ck(!latched && run == 0, "R7 supply dip clears latch", latched, 0);
    vcc_lo = 0; step(2);
    ck(run == 0, "R1 stays off without rising supply", run, 0);
    vcc_hi = 1; step(1); vcc_hi = 0; step(1);
    ck(armed, "R2 re-armed", armed, 1);
    mem = 1; win = 2'b11; step(FILT);
    ck(pg == 2'b01 && ref_o, "R8 memory mode power-good and reference", pg, 1);
    ocr = 2'b10; step(2); ocr = 0;
    ck(!latched, "R8 channel 1 overcurrent masked", latched, 0);
    ov = 2'b10; step(FILT + 1);
    ck(flo == 0, "R8 channel 1 overvoltage masked", flo, 0);
    ov = 0; step(FILT);
    ot = 1; step(FILT + 1);
    ck(run == 0 && !latched, "R9 over-temperature shutdown", run, 0);
    step(3);
    ck(run == 0, "R9 held off while hot", run, 0);
    ot = 0; ssd = 0; step(FILT + 1);
    ck(ssc && !armed, "R9 restart via soft-start", ssc, 1);
    ssd = 1; step(1);
    ck(armed, "R9 re-armed after cooling", armed, 1);
    vcc_lo = 1; step(1); vcc_lo = 0;
    ck(run == 0, "R1 supply loss while running", run, 0);
    vcc_hi = 1; step(1); vcc_hi = 0; step(1);
    en = 0; step(1);
    ck(run == 0 && pg == 0, "R11 both enables low", run, 0);
    step(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule